// File: doc/BRIEF.md
# Raster Timing Generator

The block produces the scan timing for a progressive display. A column counter runs once per pixel clock and a line counter advances each time the column wraps. From these two positions the block derives an active-video flag, a blanking flag and one sync pulse per axis, and it also drives the current column, the current line and a one-clock frame-start pulse. Between the last active pixel and the first blanked pixel on each axis there may be a border region, which is neither active nor blanked.

Timing comes from six packed 32-bit words, three per axis: total, blank and sync. Each word holds an end value in its upper half and a start value in its lower half, both stored minus one. The words, and the two sync polarity inputs, are sampled only at a frame boundary, so changing them in the middle of a frame has no effect until the next frame starts. After reset the block spends one clock taking in the words, and then starts the first frame at column 0, line 0.

Top module: `raster_timer`

## Requirements
- R1: While reset is held, and in the one clock after its release in which the timing words are first captured, col_pos and line_pos are 0, video_active is 0, blanking is 1, frame_start is 0 and both sync outputs are 0.
- R2: col_pos counts up by one per clock and returns to 0 after it equals the upper half of the horizontal total word. line_pos advances by one on each column wrap and returns to 0 after it equals the upper half of the vertical total word.
- R3: In each timing word, bits 31:16 hold (end - 1) and bits 15:0 hold (start - 1). The total word carries (active + border + blank - 1, active - 1), the blank word carries (active + border + blank - 1, active + border - 1) and the sync word carries (active + border + front porch + sync width - 1, active + border + front porch - 1).
- R4: video_active is 1 exactly when col_pos is at most the lower half of the horizontal total word and line_pos is at most the lower half of the vertical total word.
- R5: blanking is 1 exactly when col_pos lies above the lower half and at most the upper half of the horizontal blank word, or line_pos does so for the vertical blank word. Border positions are neither active nor blanked.
- R6: The horizontal sync is asserted while col_pos lies above the lower half and at most the upper half of the horizontal sync word. The vertical sync is asserted on the same rule using line_pos and the vertical sync word.
- R7: A polarity input of 1 makes that sync output low while the sync is asserted and high otherwise. A polarity input of 0 makes it high while asserted and low otherwise.
- R8: frame_start is 1 for exactly the one clock in which col_pos and line_pos are both 0.
- R9: The timing words and the polarity inputs are captured only in the clock in which the last pixel of the last line is shown, and in the first clock after reset. A change at any other time has no effect on any output until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_total_word | input | 32 | Horizontal total word: line length and active width |
| h_blank_word | input | 32 | Horizontal blanking window |
| h_sync_word | input | 32 | Horizontal sync window |
| v_total_word | input | 32 | Vertical total word: frame height and active height |
| v_blank_word | input | 32 | Vertical blanking window |
| v_sync_word | input | 32 | Vertical sync window |
| h_sync_low | input | 1 | Horizontal sync polarity, 1 = active low |
| v_sync_low | input | 1 | Vertical sync polarity, 1 = active low |
| col_pos | output | 16 | Current pixel column |
| line_pos | output | 16 | Current line |
| video_active | output | 1 | Inside the active picture |
| blanking | output | 1 | Inside horizontal or vertical blanking |
| hsync_out | output | 1 | Horizontal sync, with polarity applied |
| vsync_out | output | 1 | Vertical sync, with polarity applied |
| frame_start | output | 1 | One-clock pulse at column 0, line 0 |

## Verification
The first mode has non-zero borders on both axes and a sync window inside the blanking, so every clock shows whether border pixels are kept out of both the active and the blanked region. The second mode has no borders at all and both syncs active low. It separates a start comparison that is off by one from a correct one, and an inverted polarity from a correct one. The third mode places each sync so that it ends on the last pixel of its line or frame, which exposes errors at the window edges and at the wrap. The timing words are changed in the middle of a frame before each switch of mode, and the bench expects the old timing until the next frame, so any capture of the words outside the frame boundary shows up.

// File: rtl/raster_pkg.sv
package raster_pkg;
  parameter int POS_W = 16;
  localparam int REG_W = 2 * POS_W;
  localparam int AXES  = 2;

  typedef logic [POS_W-1:0] pos_t;

  // End-minus-one in the upper half, start-minus-one in the lower half (R3).
  typedef struct packed {
    pos_t hi;
    pos_t lo;
  } span_t;

  typedef struct packed {
    span_t total;
    span_t blank;
    span_t sync;
    logic  pol_low;
  } axis_cfg_t;

  // Position lies after the stored start-minus-one and up to the stored end-minus-one.
  function automatic logic in_span(input pos_t p, input span_t s);
    return (p > s.lo) && (p <= s.hi);
  endfunction

  // Next counter value with wrap to zero after the last position.
  function automatic pos_t step_wrap(input pos_t p, input pos_t last);
    return (p == last) ? '0 : pos_t'(p + 1'b1);
  endfunction
endpackage

// File: rtl/raster_shadow.sv
module raster_shadow
  import raster_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  axis_cfg_t cfg_in [AXES],
  output axis_cfg_t cfg_q  [AXES]
);
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q[a] <= '0;
      else if (load) cfg_q[a] <= cfg_in[a];
    end

    // R9: the captured timing only moves at a frame boundary
    assert_hold_midframe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg_q[a]));
  end
endmodule

// File: rtl/raster_counter.sv
module raster_counter
  import raster_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  pos_t h_last,
  input  pos_t v_last,
  output pos_t col,
  output pos_t line,
  output logic primed,
  output logic frame_end
);
  logic col_wrap;
  logic line_wrap;

  assign col_wrap  = (col == h_last);
  assign line_wrap = (line == v_last);
  assign frame_end = !primed || (col_wrap && line_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col    <= '0;
      line   <= '0;
      primed <= 1'b0;
    end else if (!primed) begin
      primed <= 1'b1;
      col    <= '0;
      line   <= '0;
    end else begin
      col <= step_wrap(col, h_last);
      if (col_wrap) line <= step_wrap(line, v_last);
    end
  end

  // R2: the column never passes the stored line length
  assert_col_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    col <= h_last);

  // R2: the column moves by exactly one between wraps
  assert_col_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !col_wrap |=> col == pos_t'($past(col) + 1'b1));

  // R8: a frame boundary is followed by the origin
  assert_frame_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    primed && frame_end |=> (col == '0) && (line == '0));
endmodule

// File: rtl/raster_axis_decode.sv
module raster_axis_decode
  import raster_pkg::*;
(
  input  pos_t      pos,
  input  axis_cfg_t cfg,
  output logic      in_active,
  output logic      in_blank,
  output logic      sync_on
);
  assign in_active = (pos <= cfg.total.lo);
  assign in_blank  = in_span(pos, cfg.blank);
  assign sync_on   = in_span(pos, cfg.sync);
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] h_total_word,
  input  logic [REG_W-1:0] h_blank_word,
  input  logic [REG_W-1:0] h_sync_word,
  input  logic [REG_W-1:0] v_total_word,
  input  logic [REG_W-1:0] v_blank_word,
  input  logic [REG_W-1:0] v_sync_word,
  input  logic             h_sync_low,
  input  logic             v_sync_low,
  output logic [POS_W-1:0] col_pos,
  output logic [POS_W-1:0] line_pos,
  output logic             video_active,
  output logic             blanking,
  output logic             hsync_out,
  output logic             vsync_out,
  output logic             frame_start
);
  axis_cfg_t cfg_in [AXES];
  axis_cfg_t cfg_q  [AXES];
  pos_t      pos    [AXES];
  logic [AXES-1:0] act, blk, syn, pin;
  logic primed;
  logic frame_end;
  pos_t col, line;

  always_comb begin
    cfg_in[0].total   = h_total_word;
    cfg_in[0].blank   = h_blank_word;
    cfg_in[0].sync    = h_sync_word;
    cfg_in[0].pol_low = h_sync_low;
    cfg_in[1].total   = v_total_word;
    cfg_in[1].blank   = v_blank_word;
    cfg_in[1].sync    = v_sync_word;
    cfg_in[1].pol_low = v_sync_low;
  end

  raster_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (frame_end),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  raster_counter u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_last    (cfg_q[0].total.hi),
    .v_last    (cfg_q[1].total.hi),
    .col       (col),
    .line      (line),
    .primed    (primed),
    .frame_end (frame_end)
  );

  assign pos[0] = col;
  assign pos[1] = line;

  for (genvar a = 0; a < AXES; a++) begin : g_dec
    raster_axis_decode u_dec (
      .pos       (pos[a]),
      .cfg       (cfg_q[a]),
      .in_active (act[a]),
      .in_blank  (blk[a]),
      .sync_on   (syn[a])
    );
    assign pin[a] = (primed & syn[a]) ^ cfg_q[a].pol_low;
  end

  assign col_pos      = col;
  assign line_pos     = line;
  assign video_active = primed & (&act);
  assign blanking     = !primed | (|blk);
  assign hsync_out    = pin[0];
  assign vsync_out    = pin[1];
  assign frame_start  = primed && (col == '0) && (line == '0);

  // Named condition: the captured windows are ordered active, border, blank
  logic layout_sane;
  assign layout_sane = (cfg_q[0].blank.lo >= cfg_q[0].total.lo) &&
                       (cfg_q[1].blank.lo >= cfg_q[1].total.lo);

  // R5: active picture and blanking never overlap for an ordered layout
  assert_active_not_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    video_active && layout_sane |-> !blanking);

  // R6: a horizontal sync placed inside the blank window implies blanking
  assert_hsync_in_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed && syn[0] && (cfg_q[0].sync.lo >= cfg_q[0].blank.lo) &&
    (cfg_q[0].sync.hi <= cfg_q[0].blank.hi) |-> blanking);

  // R8: the frame pulse lasts one clock unless the frame is a single pixel
  assert_frame_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && ((cfg_q[0].total.hi != '0) || (cfg_q[1].total.hi != '0))
    |=> !frame_start);
endmodule

// File: tb/raster_timer_test.sv
module raster_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] htw, hbw, hsw, vtw, vbw, vsw;
  logic hpl, vpl;
  logic [15:0] col, line;
  logic act, blk, hs, vs, fs;

  always #2.5 clk = ~clk;  // 200 MHz

  raster_timer uut (
    .clk(clk), .rst_n(rst_n),
    .h_total_word(htw), .h_blank_word(hbw), .h_sync_word(hsw),
    .v_total_word(vtw), .v_blank_word(vbw), .v_sync_word(vsw),
    .h_sync_low(hpl), .v_sync_low(vpl),
    .col_pos(col), .line_pos(line), .video_active(act), .blanking(blk),
    .hsync_out(hs), .vsync_out(vs), .frame_start(fs)
  );

  typedef struct {
    int col; int line;
    bit act; bit blk; bit hs; bit vs; bit fs;
    string tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int fails = 0;
  bit summary_done = 0;
  string phase = "R1 reset";

  // Mode description per axis: active, border, blank, front porch, sync width, polarity
  int pend_h[6], pend_v[6], cur_h[6], cur_v[6];
  bit m_primed = 0;
  int mc = 0, ml = 0;

  // R3: pack (end - 1) into bits 31:16 and (start - 1) into bits 15:0
  function automatic logic [31:0] enc(input int m[6], input int kind);
    int a, b, bl, fp, sw;
    a = m[0]; b = m[1]; bl = m[2]; fp = m[3]; sw = m[4];
    case (kind)
      0:       return {16'(a + b + bl - 1), 16'(a - 1)};
      1:       return {16'(a + b + bl - 1), 16'(a + b - 1)};
      default: return {16'(a + b + fp + sw - 1), 16'(a + b + fp - 1)};
    endcase
  endfunction

  task automatic set_mode(input int h[6], input int v[6]);
    pend_h = h; pend_v = v;
    htw = enc(h, 0); hbw = enc(h, 1); hsw = enc(h, 2);
    vtw = enc(v, 0); vbw = enc(v, 1); vsw = enc(v, 2);
    hpl = h[5][0]; vpl = v[5][0];
  endtask

  function automatic exp_t predict();
    exp_t e;
    e.tag = phase;
    e.col = mc; e.line = ml;
    if (!m_primed) begin
      e.act = 0; e.blk = 1; e.hs = 0; e.vs = 0; e.fs = 0;
    end else begin
      bit hon, von;
      e.act = (mc < cur_h[0]) && (ml < cur_v[0]);
      e.blk = (mc >= cur_h[0] + cur_h[1]) || (ml >= cur_v[0] + cur_v[1]);
      hon = (mc >= cur_h[0] + cur_h[1] + cur_h[3]) &&
            (mc <  cur_h[0] + cur_h[1] + cur_h[3] + cur_h[4]);
      von = (ml >= cur_v[0] + cur_v[1] + cur_v[3]) &&
            (ml <  cur_v[0] + cur_v[1] + cur_v[3] + cur_v[4]);
      e.hs = hon ^ cur_h[5][0];
      e.vs = von ^ cur_v[5][0];
      e.fs = (mc == 0) && (ml == 0);
    end
    return e;
  endfunction

  task automatic cmp(input string req, input string what, input string tag,
                     input int got, input int expv);
    vectors++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s [%s] %s got %0d expected %0d", req, tag, what, got, expv);
    end
  endtask

  task automatic check_item(input exp_t e);
    cmp("R2", "col", e.tag, int'(col), e.col);
    cmp("R2", "line", e.tag, int'(line), e.line);
    cmp("R4", "active", e.tag, int'(act), int'(e.act));
    cmp("R5", "blank", e.tag, int'(blk), int'(e.blk));
    cmp("R6 R7", "hsync", e.tag, int'(hs), int'(e.hs));
    cmp("R6 R7", "vsync", e.tag, int'(vs), int'(e.vs));
    cmp("R8", "frame_start", e.tag, int'(fs), int'(e.fs));
  endtask

  // Driver side of the scoreboard: reference model stepped on each edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) begin
        if (!m_primed) begin
          cur_h = pend_h; cur_v = pend_v;
          m_primed = 1; mc = 0; ml = 0;
        end else if (mc == cur_h[0] + cur_h[1] + cur_h[2] - 1) begin
          mc = 0;
          if (ml == cur_v[0] + cur_v[1] + cur_v[2] - 1) begin
            ml = 0;
            cur_h = pend_h; cur_v = pend_v;  // R9: capture at frame boundary only
          end else ml++;
        end else mc++;
        q.push_back(predict());
      end
    end
  end

  // Monitor side: pop and compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) check_item(q.pop_front());
    end
  end

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int mode_a_h[6] = '{8, 2, 6, 2, 2, 0};
    int mode_a_v[6] = '{4, 1, 3, 1, 1, 0};
    int mode_b_h[6] = '{5, 0, 4, 1, 2, 1};
    int mode_b_v[6] = '{3, 0, 2, 0, 1, 1};
    int mode_c_h[6] = '{6, 1, 3, 1, 2, 0};
    int mode_c_v[6] = '{2, 2, 2, 0, 2, 1};
    set_mode(mode_a_h, mode_a_v);
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    begin
      exp_t e;
      e = predict();
      e.tag = "R1 reset";
      check_item(e);
    end
    @(negedge clk);
    rst_n = 1'b1;
    phase = "R3 R4 R5 R6 mode with borders";
    repeat (300) @(negedge clk);
    // Mid-frame change: old timing must remain until the frame ends
    phase = "R9 mid-frame change to borderless active-low mode";
    set_mode(mode_b_h, mode_b_v);
    repeat (200) @(negedge clk);
    phase = "R9 mid-frame change to edge-aligned sync mode";
    set_mode(mode_c_h, mode_c_v);
    repeat (200) @(negedge clk);
    phase = "R7 R8 back to first mode";
    set_mode(mode_a_h, mode_a_v);
    repeat (400) @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule